// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Port

This block is a bank of general-purpose pins steered by a small synchronous register bus. Software writes an output latch in one of three ways. A full-word write replaces every bit. A write-one-to-set write forces selected bits high. A write-one-to-clear write forces selected bits low. A direction register decides which pins drive. Each pin presents an output value and an output enable to the pad ring. Each pin also returns an input level, which passes through a two-flop synchronizer before the bus can observe it.

The port width is a build-time parameter of 8, 16, 32 or 64 bits, and there is one pin per register bit. Three more build-time options adapt the block to the software that drives it. The first sets the direction polarity: a 1 bit means output, or a 1 bit means input. The second reverses the numbering, so pin n sits at register bit WIDTH-1-n. The third swaps bytes, so register words appear on the bus in big-endian byte order; it is refused at elaboration for the 64-bit width. The register bus is plain control traffic and has no back-pressure. A write is taken on any clock edge where the write strobe is high. A read strobe loads the read data register at that edge, and the value stays there until the next read.

Top module: `gpio_port`

## Requirements
- R1: A write to word offset 0 replaces the whole output latch, and pin_out follows the latch from the next cycle. When no write is made, the latch and the direction register keep their values.
- R2: A write to word offset 1 sets to 1 each latch bit whose written bit is 1. All other latch bits keep their value.
- R3: A write to word offset 2 clears to 0 each latch bit whose written bit is 1. All other latch bits keep their value.
- R4: Word offset 3 is the direction register. With DIR_ONE_IS_OUT=1, a 1 enables the pin's output; with DIR_ONE_IS_OUT=0, a 1 makes the pin an input. pin_oe changes in the cycle after the write.
- R5: A read of offset 0 returns the latch bit for each output-enabled pin and the synchronized input for each other pin. A change on pin_in is first seen by a read strobe two clock edges later.
- R6: A read of offset 1 returns the latch. A read of offset 3 returns the direction register. Reads of offset 2 and of offsets 4 to 7 return 0.
- R7: bus_rdata is loaded at the edge where bus_rd is high and holds its value otherwise. A read and a write in the same cycle return the state from before the write.
- R8: With BIT_REVERSE=1, pin n corresponds to bus bit WIDTH-1-n in every register. Otherwise pin n corresponds to bus bit n.
- R9: With BYTE_SWAP=1, byte k of the register word travels in byte lane WIDTH/8-1-k of bus_wdata and bus_rdata.
- R10: After reset the latch is 0, every pin is an input (pin_oe all 0), and bus_rdata is 0. The direction register is all 0 when DIR_ONE_IS_OUT=1 and all 1 when DIR_ONE_IS_OUT=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the register being accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin input levels |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin output enables |

## Verification
A read strobe and a write strobe can fall in the same cycle. The bench raises both on one edge, for example a read of offset 0 or 1 together with a set, clear or direction write. It judges bus_rdata against the pre-write state and the latch against the post-write state. A second collision is between a pin_in change and a read strobe one or two edges later. The per-clock model decides whether the old or the new level must come back. A second instance with 16 bits, inverted direction polarity, bit reversal and byte swap runs on the same stimulus, which covers the mapping options.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int OFF_DATA = 0;
  localparam int OFF_SET  = 1;
  localparam int OFF_CLR  = 2;
  localparam int OFF_DIR  = 3;

  typedef enum logic [1:0] {
    ACC_DATA = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_DIR  = 2'd3
  } gpio_acc_e;
endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH       = 32,
  parameter bit BIT_REVERSE = 1'b0,
  parameter bit BYTE_SWAP   = 1'b0
) (
  input  logic [WIDTH-1:0] bus_word,
  output logic [WIDTH-1:0] pin_word,
  input  logic [WIDTH-1:0] pin_back,
  output logic [WIDTH-1:0] bus_back
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] reg_fwd;
  logic [WIDTH-1:0] reg_bwd;

  generate
    if (BYTE_SWAP) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign reg_fwd[8*b +: 8]  = bus_word[8*(NBYTES-1-b) +: 8];
        assign bus_back[8*b +: 8] = reg_bwd[8*(NBYTES-1-b) +: 8];
      end
    end else begin : g_noswap
      assign reg_fwd  = bus_word;
      assign bus_back = reg_bwd;
    end

    if (BIT_REVERSE) begin : g_rev
      for (genvar n = 0; n < WIDTH; n++) begin : g_bit
        assign pin_word[n]         = reg_fwd[WIDTH-1-n];
        assign reg_bwd[WIDTH-1-n]  = pin_back[n];
      end
    end else begin : g_norev
      assign pin_word = reg_fwd;
      assign reg_bwd  = pin_back;
    end
  endgenerate
endmodule

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
      warm   <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (q == $past(d, 2))); // R5
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter int ADDR_W         = 3,
  parameter bit DIR_ONE_IS_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wpin,
  output logic [WIDTH-1:0]  latch,
  output logic [WIDTH-1:0]  dir
);
  localparam logic [WIDTH-1:0] DIR_RESET = DIR_ONE_IS_OUT ? '0 : '1;

  logic      in_range;
  gpio_acc_e acc;

  assign in_range = (int'(addr) <= OFF_DIR);
  assign acc      = gpio_acc_e'(addr[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
      dir   <= DIR_RESET;
    end else if (wr && in_range) begin
      unique case (acc)
        ACC_DATA: latch <= wpin;
        ACC_SET:  latch <= latch | wpin;
        ACC_CLR:  latch <= latch & ~wpin;
        ACC_DIR:  dir   <= wpin;
      endcase
    end
  end

  AST_DATA_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(addr) == OFF_DATA) |=> (latch == $past(wpin))); // R1
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> ($stable(latch) && $stable(dir))); // R1
  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(addr) == OFF_SET) |=> ((latch & $past(wpin)) == $past(wpin))); // R2
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(addr) == OFF_SET) |=> ((latch & ~$past(wpin)) == ($past(latch) & ~$past(wpin)))); // R2
  AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(addr) == OFF_CLR) |=> ((latch & $past(wpin)) == '0)); // R3
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(addr) == OFF_CLR) |=> ((latch & ~$past(wpin)) == ($past(latch) & ~$past(wpin)))); // R3
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter int ADDR_W         = 3,
  parameter bit DIR_ONE_IS_OUT = 1'b1,
  parameter bit BIT_REVERSE    = 1'b0,
  parameter bit BYTE_SWAP      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  generate
    if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("gpio_port: WIDTH must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
      $error("gpio_port: byte swap is not available at 64 bits");
    end
  endgenerate

  logic [WIDTH-1:0] wpin;
  logic [WIDTH-1:0] rd_pin;
  logic [WIDTH-1:0] rd_bus;
  logic [WIDTH-1:0] latch;
  logic [WIDTH-1:0] dir;
  logic [WIDTH-1:0] in_sync;

  gpio_lane_map #(
    .WIDTH(WIDTH), .BIT_REVERSE(BIT_REVERSE), .BYTE_SWAP(BYTE_SWAP)
  ) u_map (
    .bus_word(bus_wdata), .pin_word(wpin),
    .pin_back(rd_pin),    .bus_back(rd_bus)
  );

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ONE_IS_OUT(DIR_ONE_IS_OUT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wpin(wpin), .latch(latch), .dir(dir)
  );

  gpio_sync_bank #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  assign pin_oe  = DIR_ONE_IS_OUT ? dir : ~dir;
  assign pin_out = latch;

  always_comb begin
    rd_pin = '0;
    if (int'(bus_addr) == OFF_DATA)     rd_pin = (latch & pin_oe) | (in_sync & ~pin_oe);
    else if (int'(bus_addr) == OFF_SET) rd_pin = latch;
    else if (int'(bus_addr) == OFF_DIR) rd_pin = dir;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd) |=> $stable(bus_rdata)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (int'(bus_addr) > OFF_DIR || int'(bus_addr) == OFF_CLR)) |=> (bus_rdata == '0)); // R6
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == OFF_DIR)
      |=> (pin_oe == (DIR_ONE_IS_OUT ? $past(wpin) : ~$past(wpin)))); // R4
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) == OFF_DATA) |=> (pin_out == $past(wpin))); // R1
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pin_in = '0;
  logic [31:0] rdata0, pout0, poe0;
  logic [15:0] rdata1, pout1, poe1;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Main instance: 32 bits, 1 = output, plain numbering and byte order
  gpio_port #(.WIDTH(32), .ADDR_W(3), .DIR_ONE_IS_OUT(1'b1),
              .BIT_REVERSE(1'b0), .BYTE_SWAP(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata0),
    .pin_in(pin_in), .pin_out(pout0), .pin_oe(poe0));

  // Second instance: 16 bits, 1 = input, reversed bits, swapped bytes (R8 R9)
  gpio_port #(.WIDTH(16), .ADDR_W(3), .DIR_ONE_IS_OUT(1'b0),
              .BIT_REVERSE(1'b1), .BYTE_SWAP(1'b1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata[15:0]), .bus_rd(bus_rd), .bus_rdata(rdata1),
    .pin_in(pin_in[15:0]), .pin_out(pout1), .pin_oe(poe1));

  // Reference state
  logic [31:0] m_lat0, m_dir0, m_s10, m_s20, m_rd0;
  logic [15:0] m_lat1, m_dir1, m_s11, m_s21, m_rd1;

  function automatic logic [15:0] alt_to_pin(input logic [15:0] b);
    logic [15:0] r, p;
    r = {b[7:0], b[15:8]};
    for (int n = 0; n < 16; n++) p[n] = r[15-n];
    return p;
  endfunction

  function automatic logic [15:0] alt_to_bus(input logic [15:0] p);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) r[15-n] = p[n];
    return {r[7:0], r[15:8]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat0 = '0; m_dir0 = '0;  m_s10 = '0; m_s20 = '0; m_rd0 = '0;
      m_lat1 = '0; m_dir1 = '1;  m_s11 = '0; m_s21 = '0; m_rd1 = '0;
    end else begin
      logic [31:0] v0;
      logic [15:0] v1, w1, oe1;
      v0 = 32'h0;
      case (bus_addr)
        3'd0: v0 = (m_lat0 & m_dir0) | (m_s20 & ~m_dir0);
        3'd1: v0 = m_lat0;
        3'd3: v0 = m_dir0;
        default: v0 = 32'h0;
      endcase
      oe1 = ~m_dir1;
      v1 = 16'h0;
      case (bus_addr)
        3'd0: v1 = (m_lat1 & oe1) | (m_s21 & ~oe1);
        3'd1: v1 = m_lat1;
        3'd3: v1 = m_dir1;
        default: v1 = 16'h0;
      endcase
      if (bus_rd) begin
        m_rd0 = v0;
        m_rd1 = alt_to_bus(v1);
      end
      w1 = alt_to_pin(bus_wdata[15:0]);
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_lat0 = bus_wdata; m_lat1 = w1; end
          3'd1: begin m_lat0 = m_lat0 | bus_wdata; m_lat1 = m_lat1 | w1; end
          3'd2: begin m_lat0 = m_lat0 & ~bus_wdata; m_lat1 = m_lat1 & ~w1; end
          3'd3: begin m_dir0 = bus_wdata; m_dir1 = w1; end
          default: ;
        endcase
      end
      m_s20 = m_s10; m_s10 = pin_in;
      m_s21 = m_s11; m_s11 = pin_in[15:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pout0 == m_lat0, "R1 R2 R3 pin_out", pout0, m_lat0);
      chk(poe0 == m_dir0, "R4 pin_oe (1=out)", poe0, m_dir0);
      chk(rdata0 == m_rd0, "R5 R6 R7 rdata", rdata0, m_rd0);
      chk(pout1 == m_lat1, "R8 alt pin_out", {16'h0, pout1}, {16'h0, m_lat1});
      chk(poe1 == ~m_dir1, "R4 R8 alt pin_oe (1=in)", {16'h0, poe1}, {16'h0, ~m_dir1});
      chk(rdata1 == m_rd1, "R9 R6 alt rdata", {16'h0, rdata1}, {16'h0, m_rd1});
    end
  end

  task automatic op(input bit wr, input bit rd, input logic [2:0] a,
                    input logic [31:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(pout0 == 32'h0 && poe0 == 32'h0, "R10 reset pins", poe0 | pout0, 32'h0);
    chk(pout1 == 16'h0 && poe1 == 16'h0, "R10 reset alt pins", {16'h0, poe1 | pout1}, 32'h0);
    chk(rdata0 == 32'h0 && rdata1 == 16'h0, "R10 reset rdata", rdata0, 32'h0);
    op(1'b0, 1'b1, 3'd3, 32'h0);
    chk(rdata1 == 16'hFFFF, "R10 alt direction reset all ones", {16'h0, rdata1}, 32'hFFFF);

    // R1 R2 R3 latch writes
    op(1'b1, 1'b0, 3'd0, 32'hA5A5_3C3C);
    chk(pout0 == 32'hA5A5_3C3C, "R1 full write", pout0, 32'hA5A5_3C3C);
    op(1'b1, 1'b0, 3'd1, 32'h0F0F_00F0);
    chk(pout0 == 32'hAFAF_3CFC, "R2 set write", pout0, 32'hAFAF_3CFC);
    op(1'b1, 1'b0, 3'd2, 32'h00FF_0003);
    chk(pout0 == 32'hAF00_3CFC, "R3 clear write", pout0, 32'hAF00_3CFC);
    // R8 R9: 0x0001 on the bus is byte 1 bit 0 -> register bit 8 -> pin 7
    op(1'b1, 1'b0, 3'd0, 32'h0000_0001);
    chk(pout1 == 16'h0080, "R8 R9 mapping of bus bit 0", {16'h0, pout1}, 32'h0080);

    // R4 direction and R5 mixed read
    pin_in = 32'h1234_5678;
    op(1'b1, 1'b0, 3'd3, 32'hFFFF_0000);
    chk(poe0 == 32'hFFFF_0000, "R4 direction output mode", poe0, 32'hFFFF_0000);
    op(1'b1, 1'b0, 3'd0, 32'hDEAD_BEEF);
    for (int a = 0; a < 8; a++) op(1'b0, 1'b1, 3'(a), 32'h0);
    op(1'b0, 1'b1, 3'd0, 32'h0);
    chk(rdata0 == 32'hDEAD_5678, "R5 mixed data read", rdata0, 32'hDEAD_5678);

    // R7 read and write together
    op(1'b1, 1'b1, 3'd1, 32'h0000_FFFF);
    chk(rdata0 == 32'hDEAD_BEEF, "R7 read sees pre-write latch", rdata0, 32'hDEAD_BEEF);
    op(1'b1, 1'b1, 3'd3, 32'h0000_00FF);
    op(1'b1, 1'b1, 3'd0, 32'h1357_9BDF);
    op(1'b1, 1'b1, 3'd2, 32'hFFFF_0000);
    op(1'b0, 1'b1, 3'd0, 32'h0);

    // R5 input latency: change pins and read at once, then again
    @(negedge clk); pin_in = 32'hCAFE_F00D; bus_rd = 1'b1; bus_addr = 3'd0;
    @(negedge clk); @(negedge clk); @(negedge clk); bus_rd = 1'b0;
    op(1'b1, 1'b0, 3'd3, 32'h0);
    pin_in = 32'h0F0F_F0F0;
    op(1'b0, 1'b1, 3'd0, 32'h0);
    op(1'b0, 1'b1, 3'd0, 32'h0);
    chk(rdata0 == 32'h0F0F_F0F0, "R5 input visible after sync", rdata0, 32'h0F0F_F0F0);

    // R6 unused offsets and clear read
    op(1'b0, 1'b1, 3'd6, 32'h0);
    chk(rdata0 == 32'h0, "R6 unused offset reads 0", rdata0, 32'h0);
    op(1'b0, 1'b1, 3'd2, 32'h0);
    chk(rdata0 == 32'h0, "R6 clear offset reads 0", rdata0, 32'h0);

    for (int i = 0; i < 40; i++)
      op(1'(i % 3 == 0), 1'(i % 2 == 0), 3'(i * 5), 32'h9E37_79B9 * (i + 1));
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule